// File: doc/BRIEF.md
# Dual-Structure 16-bit Maximal-Length Sequence Generator

This block produces a pseudo-random 16-bit state sequence and a serial bit stream from the primitive polynomial x^16 + x^14 + x^13 + x^11 + 1. It can advance in either of two feedback structures. In the many-to-one structure, several state bits are folded by XOR into one new bit that enters the top of the register. In the one-to-many structure, the bit leaving the bottom toggles a fixed set of positions as the word shifts. Both structures visit every non-zero 16-bit value once per period.

The structure is chosen by the `MODE_CFG` parameter. It can be fixed to one structure, or left to the `mode_i` input so that it may change from one cycle to the next. A seed strobe loads a new starting word and takes priority over stepping. A zero seed is replaced by a fixed non-zero word, so the register can never lock up. While `en` is low the state holds. A synchronous reset restores the default seed.

Top module: `prng16_dual`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0xACE1, so `state_o` reads 0xACE1 and `out_bit` reads 1 after reset.
- R2: With `mode_i` = 0 (many-to-one), `en` = 1 and `seed_ld` = 0, the next state is the old state shifted right by one. Bit 15 takes the XOR of old bits 0, 2, 3 and 5. From 0xACE1 the next state is 0x5670.
- R3: With `mode_i` = 1 (one-to-many), `en` = 1 and `seed_ld` = 0, the next state is the old state shifted right by one with a 0 entering bit 15. That word is then XORed with 0xB400 only when old bit 0 was 1. From 0xACE1 the next state is 0xE270.
- R4: In each mode, stepping every cycle from 0xACE1 returns to 0xACE1 after exactly 65535 steps and not earlier.
- R5: After reset, the state is never 0x0000.
- R6: When `seed_ld` is 1 at a rising edge, the state becomes `seed_val` regardless of `en` and `mode_i`.
- R7: A loaded `seed_val` of 0x0000 is replaced by 0x0001.
- R8: When `en` and `seed_ld` are both 0 at a rising edge, the state does not change.
- R9: `out_bit` always equals bit 0 of `state_o`.
- R10: With `MODE_CFG` = 0, the structure used at each edge is the one `mode_i` selects at that edge, so the mode may change on any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads 0xACE1 |
| en | input | 1 | Advance the sequence by one step |
| seed_ld | input | 1 | Load `seed_val` at this edge (wins over `en`) |
| seed_val | input | 16 | Seed word; zero is replaced by 0x0001 |
| mode_i | input | 1 | 0 = many-to-one step, 1 = one-to-many step (used when `MODE_CFG` = 0) |
| state_o | output | 16 | Current register word |
| out_bit | output | 1 | Serial output, bit 0 of the state |

## Verification
Three functions can fall in the same cycle: a seed load, an enabled step, and a change of structure. The load must win, and it must also apply the zero substitution. The random phase drives `seed_ld`, `en` and `mode_i` independently, with zero seeds often in the mix, so all three land together many times. Directed cases add a zero seed with `en` high and a mode flip on the load edge. Every cycle is judged against a bench model that applies the load first, then the step for the sampled mode, and then compares the full state word.

// File: rtl/prng_pkg.sv
package prng_pkg;
   localparam int unsigned PRNG_W = 16;

   typedef enum logic {
      STEP_MANY_TO_ONE = 1'b0,
      STEP_ONE_TO_MANY = 1'b1
   } step_mode_e;

   // structure choice made at elaboration
   localparam int unsigned CFG_RUNTIME = 0;
   localparam int unsigned CFG_FIX_M2O = 1;
   localparam int unsigned CFG_FIX_O2M = 2;
endpackage

// File: rtl/prng_m2o_step.sv
module prng_m2o_step #(
   parameter int unsigned          W        = 16,
   parameter logic [W-1:0]         TAP_SEL  = 16'h002D
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o
);
   logic fold;

   if (W < 2) begin : g_w_bad
      $error("prng_m2o_step: W must be at least 2");
   end
   if (TAP_SEL[0] != 1'b1) begin : g_tap_bad
      $error("prng_m2o_step: output bit must be one of the taps");
   end

   always_comb begin
      fold  = ^(cur_i & TAP_SEL);
      nxt_o = {fold, cur_i[W-1:1]};
   end
endmodule

// File: rtl/prng_o2m_step.sv
module prng_o2m_step #(
   parameter int unsigned  W        = 16,
   parameter logic [W-1:0] FLIP_SEL = 16'hB400
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o
);
   localparam logic [W-1:0] ZERO_W = '0;

   if (FLIP_SEL[W-1] != 1'b1) begin : g_flip_bad
      $error("prng_o2m_step: top bit of the flip set must be 1");
   end

   always_comb begin
      nxt_o = {1'b0, cur_i[W-1:1]} ^ (cur_i[0] ? FLIP_SEL : ZERO_W);
   end
endmodule

// File: rtl/prng_seed_guard.sv
module prng_seed_guard #(
   parameter int unsigned  W        = 16,
   parameter logic [W-1:0] SUBST    = 16'h0001
) (
   input  logic [W-1:0] seed_i,
   output logic [W-1:0] safe_o
);
   if (SUBST == '0) begin : g_subst_bad
      $error("prng_seed_guard: substitute word must be non-zero");
   end

   always_comb begin
      safe_o = (seed_i == '0) ? SUBST : seed_i;
   end
endmodule

// File: rtl/prng16_dual.sv
module prng16_dual
   import prng_pkg::*;
#(
   parameter int unsigned       W         = PRNG_W,
   parameter logic [W-1:0]      TAP_SEL   = 16'h002D,
   parameter logic [W-1:0]      FLIP_SEL  = 16'hB400,
   parameter logic [W-1:0]      RST_WORD  = 16'hACE1,
   parameter logic [W-1:0]      ZERO_SUB  = 16'h0001,
   parameter int unsigned       MODE_CFG  = CFG_RUNTIME
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         seed_ld,
   input  logic [W-1:0] seed_val,
   input  logic         mode_i,
   output logic [W-1:0] state_o,
   output logic         out_bit
);
   localparam int unsigned TOP = W - 1;

   if (RST_WORD == '0) begin : g_rst_bad
      $error("prng16_dual: reset word must be non-zero");
   end
   if (MODE_CFG > CFG_FIX_O2M) begin : g_cfg_bad
      $error("prng16_dual: MODE_CFG must be 0, 1 or 2");
   end

   logic [W-1:0] st_q;
   logic [W-1:0] m2o_nxt;
   logic [W-1:0] o2m_nxt;
   logic [W-1:0] seed_safe;
   logic [W-1:0] step_nxt;
   step_mode_e   eff_mode;

   prng_m2o_step #(.W(W), .TAP_SEL(TAP_SEL)) u_m2o (
      .cur_i (st_q),
      .nxt_o (m2o_nxt)
   );

   prng_o2m_step #(.W(W), .FLIP_SEL(FLIP_SEL)) u_o2m (
      .cur_i (st_q),
      .nxt_o (o2m_nxt)
   );

   prng_seed_guard #(.W(W), .SUBST(ZERO_SUB)) u_guard (
      .seed_i (seed_val),
      .safe_o (seed_safe)
   );

   if (MODE_CFG == CFG_FIX_M2O) begin : g_fix_m2o
      assign eff_mode = STEP_MANY_TO_ONE;
   end else if (MODE_CFG == CFG_FIX_O2M) begin : g_fix_o2m
      assign eff_mode = STEP_ONE_TO_MANY;
   end else begin : g_runtime
      assign eff_mode = step_mode_e'(mode_i);
   end

   always_comb begin
      step_nxt = (eff_mode == STEP_ONE_TO_MANY) ? o2m_nxt : m2o_nxt;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= RST_WORD;
      end else if (seed_ld) begin
         st_q <= seed_safe;
      end else if (en) begin
         st_q <= step_nxt;
      end
   end

   assign state_o = st_q;
   assign out_bit = st_q[0];

   // ---------------- checks ----------------
   logic seen_q;
   always_ff @(posedge clk) begin
      seen_q <= 1'b1;
   end

   // R1
   reset_word_chk: assert property (@(posedge clk)
      seen_q && $past(rst) |-> state_o == RST_WORD);

   // R5
   never_zero_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && !$past(rst) |-> state_o != '0);

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && $past(!rst && !seed_ld && !en) |-> state_o == $past(state_o));

   // R6 R7
   seed_load_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && $past(!rst && seed_ld) |->
         state_o == (($past(seed_val) == '0) ? ZERO_SUB : $past(seed_val)));

   // R2
   m2o_shift_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && $past(!rst && !seed_ld && en && eff_mode == STEP_MANY_TO_ONE)
         |-> state_o[TOP-1:0] == $past(state_o[TOP:1]));

   // R3
   o2m_carry_chk: assert property (@(posedge clk) disable iff (rst)
      seen_q && $past(!rst && !seed_ld && en && eff_mode == STEP_ONE_TO_MANY)
         |-> state_o[TOP] == $past(state_o[0]));
endmodule

// File: tb/prng16_dual_test.sv
module prng16_dual_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        en;
   logic        seed_ld;
   logic [15:0] seed_val;
   logic        mode_i;
   logic [15:0] state_o;
   logic        out_bit;

   int unsigned total = 0;
   int unsigned bad   = 0;
   int unsigned cyc   = 0;
   logic [15:0] exp_st;

   always #5 clk = ~clk;

   prng16_dual uut (
      .clk(clk), .rst(rst), .en(en), .seed_ld(seed_ld),
      .seed_val(seed_val), .mode_i(mode_i),
      .state_o(state_o), .out_bit(out_bit)
   );

   function automatic logic [15:0] ref_m2o(input logic [15:0] s);
      logic b;
      b = s[0] ^ s[2] ^ s[3] ^ s[5];
      return {b, s[15:1]};
   endfunction

   function automatic logic [15:0] ref_o2m(input logic [15:0] s);
      logic [15:0] r;
      r = s >> 1;
      if (s[0]) r = r ^ 16'hB400;
      return r;
   endfunction

   function automatic logic [15:0] ref_next(input logic [15:0] s, input logic r,
         input logic e, input logic ld, input logic [15:0] sd, input logic m);
      if (r)       return 16'hACE1;
      if (ld)      return (sd == 16'h0000) ? 16'h0001 : sd;
      if (!e)      return s;
      return m ? ref_o2m(s) : ref_m2o(s);
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, model predicts value after next posedge
   task automatic drive(input logic r, input logic e, input logic ld,
         input logic [15:0] sd, input logic m);
      rst = r; en = e; seed_ld = ld; seed_val = sd; mode_i = m;
      exp_st = ref_next(exp_st, r, e, ld, sd, m);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      int unsigned steps;
      logic        early;
      logic        zero_seen;
      logic        mism;
      void'($urandom(32'h1234_5678));
      exp_st = 16'h0000;
      rst = 1'b1; en = 1'b0; seed_ld = 1'b0; seed_val = '0; mode_i = 1'b0;
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b1, 16'h1111, 1'b1);
      // R1 reset word and serial bit
      check("R1 reset state", state_o, 16'hACE1);
      check("R9 out_bit after reset", {15'd0, out_bit}, 16'h0001);

      // R2 known next state
      drive(1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
      check("R2 many-to-one from ACE1", state_o, 16'h5670);
      // R3 known next state
      drive(1'b0, 1'b0, 1'b1, 16'hACE1, 1'b0);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
      check("R3 one-to-many from ACE1", state_o, 16'hE270);
      // R8 hold
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
      check("R8 hold with en low", state_o, 16'hE270);
      // R7 zero seed with en high: load wins and is substituted (R6)
      drive(1'b0, 1'b1, 1'b1, 16'h0000, 1'b1);
      check("R7 zero seed -> 0001", state_o, 16'h0001);
      // R6 load wins over step, mode flip on load edge
      drive(1'b0, 1'b1, 1'b1, 16'h8001, 1'b0);
      check("R6 load beats enable", state_o, 16'h8001);
      // R10 mode change each cycle
      drive(1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
      check("R10 step in one-to-many", state_o, exp_st);
      drive(1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
      check("R10 step in many-to-one", state_o, exp_st);

      // R4 period in each mode
      for (int md = 0; md < 2; md++) begin
         drive(1'b0, 1'b0, 1'b1, 16'hACE1, md[0]);
         steps = 0; early = 1'b0; zero_seen = 1'b0; mism = 1'b0;
         for (int k = 0; k < 65535; k++) begin
            drive(1'b0, 1'b1, 1'b0, 16'h0, md[0]);
            steps++;
            if (state_o == 16'h0000) zero_seen = 1'b1;
            if (state_o !== exp_st) mism = 1'b1;
            if (state_o == 16'hACE1 && k != 65534) early = 1'b1;
         end
         check(md ? "R4 one-to-many period end" : "R4 many-to-one period end",
               state_o, 16'hACE1);
         check("R4 no early return", {15'd0, early}, 16'h0000);
         check("R5 no zero state in period", {15'd0, zero_seen}, 16'h0000);
         check("R2 R3 period matches model", {15'd0, mism}, 16'h0000);
      end

      // random mix: load, enable and mode collide
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] sd;
         sd = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
         drive(1'b0, $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
               sd, 1'($urandom));
         check("R6 R7 R8 R10 random mix", state_o, exp_st);
         check("R9 out_bit equals bit 0", {15'd0, out_bit}, {15'd0, state_o[0]});
         if (state_o == 16'h0000) check("R5 nonzero in random mix", state_o, 16'hFFFF);
      end

      // reset mid-run
      drive(1'b1, 1'b1, 1'b0, 16'h0, 1'b1);
      check("R1 reset mid-run", state_o, 16'hACE1);
      finish_run();
   end
endmodule